// File: doc/BRIEF.md
# Two-Phase Gray/Binary Code Converter

This block converts a 32-bit word between reflected binary Gray code and plain binary, in either direction. A caller raises a start strobe for one cycle with a direction select and an operand. The block answers with a registered result and a one-cycle done strobe.

Encoding to Gray is a single XOR of the operand with a copy of itself shifted right by one position, so the result comes one cycle after the start. Decoding from Gray is a running XOR that flows from the most significant bit down to bit 0. Its full length would make one long serial path. The block therefore cuts it in half. On the edge that accepts the request, the upper 16 result bits are resolved and registered. On the next edge, the lower 16 bits are resolved from the registered bit 16. While the second half is pending, a busy flag is high and any new start is dropped.

The sequencing uses two named states. `ST_IDLE` accepts requests. The transition `T_ACCEPT_DEC` (start with direction = decode) moves to `ST_LOWER`. The transition `T_ACCEPT_ENC` (start with direction = encode) stays in `ST_IDLE` and completes at once. `ST_LOWER` always leaves through `T_FINISH` back to `ST_IDLE`, whatever the start input does.

Top module: `gray_bin_conv`

## Requirements
- R1: After reset, `result_o` is 0 and both `done_o` and `busy_o` are 0.
- R2: When `start_i` is 1 and `to_bin_i` is 0 (encode) while `busy_o` is 0, the next edge loads `result_o` with `operand_i ^ (operand_i >> 1)` and raises `done_o` for that cycle. `busy_o` stays 0.
- R3: When `start_i` is 1 and `to_bin_i` is 1 (decode) while `busy_o` is 0, `busy_o` is 1 for exactly one cycle after the accepting edge. On the following edge `done_o` rises with the result and `busy_o` returns to 0.
- R4: The decoded result satisfies b[31] = g[31] and b[i] = b[i+1] ^ g[i] for i from 30 down to 0. This includes the step from bit 16 to bit 15, where the two halves meet.
- R5: A start seen while `busy_o` is 1 is ignored. It produces no extra `done_o`, does not change the pending result, and `result_o` keeps its value afterwards.
- R6: `result_o` changes only on a cycle where `done_o` is 1. `done_o` is 0 in every cycle in which no conversion completes.
- R7: Encoding any value and then decoding the encoded result returns the original value.
- R8: Encode requests may be issued on consecutive cycles, including the cycle in which a decode's `done_o` is high. Each one yields its own `done_o` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, sampled on each rising edge |
| to_bin_i | input | 1 | 0 = binary to Gray, 1 = Gray to binary |
| operand_i | input | 32 | Value to convert, sampled with the start |
| result_o | output | 32 | Registered conversion result |
| done_o | output | 1 | One-cycle strobe: `result_o` was just loaded |
| busy_o | output | 1 | Decode second half pending; starts ignored |

## Verification
The bench tries the encoder and the decoder with walking single bits, all-ones, alternating patterns and pseudo-random words. A walking one tells apart a correct shift direction from a reversed one. Words whose Gray bit 16 or bit 15 differ show whether the lower half is seeded from the registered bit 16 rather than from the raw input. Starts asserted during the busy cycle, with a different operand, separate a correctly dropped request from one that corrupts or repeats the result. Encode followed by decode of the same word checks the round trip. Encode requests issued back to back check that accepting a start in the cycle where `done_o` is high does not lose a request.

// File: rtl/gbc_pkg.sv
package gbc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_LOWER = 1'b1
    } gbc_state_e;
endpackage

// File: rtl/gbc_b2g.sv
module gbc_b2g #(
    parameter int W = 32
) (
    input  logic [W-1:0] bin_i,
    output logic [W-1:0] gray_o
);
    always_comb begin
        gray_o = bin_i ^ (bin_i >> 1);
    end
endmodule

// File: rtl/gbc_prefix_seg.sv
// One segment of the Gray-to-binary running XOR, from its top bit down.
module gbc_prefix_seg #(
    parameter int W = 16
) (
    input  logic         seed_i,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    assign bin_o[W-1] = seed_i ^ gray_i[W-1];

    for (genvar i = W - 2; i >= 0; i--) begin : g_stage
        assign bin_o[i] = bin_o[i+1] ^ gray_i[i];
    end
endmodule

// File: rtl/gbc_ctrl.sv
module gbc_ctrl
    import gbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic to_bin_i,
    output logic load_enc_o,
    output logic load_hi_o,
    output logic load_lo_o,
    output logic busy_o
);
    gbc_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i && to_bin_i) state_d = ST_LOWER;   // T_ACCEPT_DEC
            end
            ST_LOWER: state_d = ST_IDLE;                       // T_FINISH
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        load_enc_o = 1'b0;
        load_hi_o  = 1'b0;
        load_lo_o  = 1'b0;
        busy_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_enc_o = start_i && !to_bin_i;             // T_ACCEPT_ENC
                load_hi_o  = start_i && to_bin_i;
            end
            ST_LOWER: begin
                load_lo_o = 1'b1;
                busy_o    = 1'b1;
            end
            default: ;
        endcase
    end

    // R3 / R5: the pending state lasts exactly one cycle, starts cannot extend it
    a_r5_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o);
    // R2: an encode request never raises busy
    a_r2_enc_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !to_bin_i && !busy_o) |=> !busy_o);
endmodule

// File: rtl/gray_bin_conv.sv
module gray_bin_conv #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             to_bin_i,
    input  logic [WIDTH-1:0] operand_i,
    output logic [WIDTH-1:0] result_o,
    output logic             done_o,
    output logic             busy_o
);
    localparam int LO_W = WIDTH / 2;
    localparam int HI_W = WIDTH - LO_W;

    logic load_enc, load_hi, load_lo;
    logic [WIDTH-1:0] enc_val;
    logic [HI_W-1:0]  hi_bin;
    logic [LO_W-1:0]  lo_bin;
    logic [HI_W-1:0]  hi_q;
    logic [LO_W-1:0]  lo_gray_q;

    gbc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .to_bin_i   (to_bin_i),
        .load_enc_o (load_enc),
        .load_hi_o  (load_hi),
        .load_lo_o  (load_lo),
        .busy_o     (busy_o)
    );

    gbc_b2g #(.W(WIDTH)) u_enc (
        .bin_i  (operand_i),
        .gray_o (enc_val)
    );

    // First phase: top half, seeded with 0 so b[top] = g[top]
    gbc_prefix_seg #(.W(HI_W)) u_hi (
        .seed_i (1'b0),
        .gray_i (operand_i[WIDTH-1:LO_W]),
        .bin_o  (hi_bin)
    );

    // Second phase: bottom half, seeded from the registered lowest bit of the top half
    gbc_prefix_seg #(.W(LO_W)) u_lo (
        .seed_i (hi_q[0]),
        .gray_i (lo_gray_q),
        .bin_o  (lo_bin)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q      <= '0;
            lo_gray_q <= '0;
        end else if (load_hi) begin
            hi_q      <= hi_bin;
            lo_gray_q <= operand_i[LO_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= load_enc || load_lo;
            if (load_enc)     result_o <= enc_val;
            else if (load_lo) result_o <= {hi_q, lo_bin};
        end
    end

    // R3: the cycle after busy always completes
    a_r3_busy_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> done_o);
    // R2: an accepted encode completes on the next edge
    a_r2_enc_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !to_bin_i && !busy_o) |=> done_o);
    // R6: the result only moves when done is raised
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
    // R5: a start while busy does not complete a second time after the finish
    a_r5_no_extra_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !(start_i && !to_bin_i)) |=> ##1 (!done_o || $past(start_i)));
endmodule

// File: tb/gray_bin_conv_test.sv
module gray_bin_conv_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        to_bin_i = 1'b0;
    logic [31:0] operand_i = '0;
    logic [31:0] result_o;
    logic        done_o;
    logic        busy_o;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    gray_bin_conv uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .to_bin_i(to_bin_i),
        .operand_i(operand_i), .result_o(result_o), .done_o(done_o), .busy_o(busy_o)
    );

    function automatic logic [31:0] ref_enc(input logic [31:0] b);
        return b ^ {1'b0, b[31:1]};
    endfunction

    function automatic logic [31:0] ref_dec(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops an expected item every time done is seen
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected done", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, result_o, e);
            end
        end
    end

    // Encode: drive at negedge, done one cycle later
    task automatic do_enc(input logic [31:0] v, input string tag);
        start_i = 1'b1; to_bin_i = 1'b0; operand_i = v;
        exp_q.push_back(ref_enc(v)); tag_q.push_back(tag);
        @(negedge clk);
        start_i = 1'b0;
        check("R2 done after encode", {31'd0, done_o}, 32'd1);
        check("R2 busy stays low", {31'd0, busy_o}, 32'd0);
    endtask

    // Decode, optionally poking a start during the busy cycle
    task automatic do_dec(input logic [31:0] g, input bit poke, input string tag);
        start_i = 1'b1; to_bin_i = 1'b1; operand_i = g;
        exp_q.push_back(ref_dec(g)); tag_q.push_back(tag);
        @(negedge clk);
        check("R3 busy after accept", {31'd0, busy_o}, 32'd1);
        check("R3 no done yet", {31'd0, done_o}, 32'd0);
        if (poke) begin
            start_i = 1'b1; to_bin_i = poke ? ~g[0] : 1'b0; operand_i = ~g;
        end else begin
            start_i = 1'b0;
        end
        @(negedge clk);
        start_i = 1'b0;
        check("R3 done second cycle", {31'd0, done_o}, 32'd1);
        check("R3 busy released", {31'd0, busy_o}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : driver
        logic [31:0] seed;
        logic [31:0] held;
        seed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 result after reset", result_o, 32'd0);
        check("R1 done after reset", {31'd0, done_o}, 32'd0);
        check("R1 busy after reset", {31'd0, busy_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 idle no done", {31'd0, done_o}, 32'd0);

        // R2 encode patterns
        for (int i = 0; i < 32; i++) do_enc(32'd1 << i, "R2 walking one encode");
        do_enc(32'hFFFF_FFFF, "R2 all ones encode");
        do_enc(32'hAAAA_AAAA, "R2 alternating encode");
        do_enc(32'h0000_0000, "R2 zero encode");

        // R4 decode patterns, including the bit16/bit15 meeting point
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            do_dec(32'd1 << i, 1'b0, "R4 walking one decode");
            @(negedge clk);
        end
        do_dec(32'h0001_0000, 1'b0, "R4 seed from bit 16");
        do_dec(32'h0000_8000, 1'b0, "R4 bit 15 alone");
        do_dec(32'hFFFF_FFFF, 1'b0, "R4 all ones decode");
        do_dec(32'h5555_5555, 1'b0, "R4 alternating decode");

        // R5 starts while busy are ignored
        for (int k = 0; k < 6; k++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            do_dec(seed, 1'b1, "R5 decode with ignored start");
            held = result_o;
            @(negedge clk);
            check("R5 no extra done", {31'd0, done_o}, 32'd0);
            check("R5 result kept", result_o, held);
        end

        // R7 round trip
        for (int k = 0; k < 40; k++) begin
            logic [31:0] g;
            seed = seed * 32'd1664525 + 32'd1013904223;
            do_enc(seed, "R7 round trip encode");
            g = result_o;
            do_dec(g, 1'b0, "R7 round trip decode");
            check("R7 round trip value", result_o, seed);
        end

        // R8 back to back encodes, and an encode in the decode's done cycle
        for (int k = 0; k < 8; k++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            do_enc(seed, "R8 back to back encode");
        end
        do_dec(32'hC3A5_0F96, 1'b0, "R8 decode before chained encode");
        do_enc(32'h8000_0001, "R8 encode in done cycle");

        // R6 hold while idle
        held = result_o;
        repeat (4) @(negedge clk);
        check("R6 result holds idle", result_o, held);
        check("R6 queue drained", exp_q.size(), 32'd0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule